// File: doc/BRIEF.md
# Multithread Interrupt Acceptance Unit

This unit keeps the shared interrupt state of a small multithreaded core: a pending vector and a sticky auto-disable vector, one bit of each per interrupt line. In every cycle it checks the pending lines against the per-thread controls. These controls are an interrupt enable, an exception-active flag, a per-line mask, a priority value, a run mode and two program counters. From them it picks at most one line and the one hardware thread that takes that line.

When a line is taken, the unit clears its pending bit and sets its auto-disable bit. It then emits a registered acceptance record for one cycle. The record holds the thread index, the line number, the cause code the thread loads with its exception-active flag, the exception-return address and the redirect PC into the event vector table. A raise port and a clear port edit the pending vector. While any line is pending, every thread that is not switched off gets a wake request.

Top module: `irq_accept_unit`

## Requirements
- R1: Synchronous active-high reset clears the pending vector, the auto-disable vector and the acceptance valid output.
- R2: A raise mask ORs into the pending vector and a clear mask removes its bits from it. On a bit named by both, the raise wins. An all-zero mask changes nothing. The new vector is visible one clock after the masks are applied.
- R3: A thread is qualified for line i only when all of these hold: the global enable is 1, auto-disable bit i is 0, the thread's enable is 1, its exception-active input is 0, and bit i of its mask is 0.
- R4: Lines are examined from index 0 upward. The lowest-numbered line that is pending, not auto-disabled and has a qualified thread is taken. At most one line is taken per cycle.
- R5: With scheduling enable at 1, the line goes to the qualified thread with the numerically largest priority value, and ties go to the lowest thread index. With scheduling enable at 0, priority is ignored and the lowest-index qualified thread wins.
- R6: Taking line i clears pending bit i and sets auto-disable bit i. The clear wins over a raise of bit i in the same cycle. An auto-disabled line is never taken again until reset.
- R7: The cause output is CAUSE_BASE (default 0xC0) ORed with the line number.
- R8: The redirect PC is the vector base ORed with (EVT_BASE + line) shifted left by 2, with EVT_BASE defaulting to 16.
- R9: Thread modes are encoded 0 = off, 1 = wait, 2 and 3 = running. If the chosen thread is in wait mode, the return address is its wait-resume PC and the leave-wait flag is 1. Otherwise the return address is its current PC and the flag is 0.
- R10: While any pending bit is 1, the wake output of every thread whose mode is not off is 1. Threads in off mode never get a wake request.
- R11: The acceptance record is registered. The valid output is 1 in the cycle after the decision and stays 1 for one cycle per acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gie_i | input | 1 | Global interrupt enable |
| sched_en_i | input | 1 | Priority-based thread selection enable |
| raise_i | input | N_LINES | Mask of lines to set pending |
| clear_i | input | N_LINES | Mask of lines to clear pending |
| vec_base_i | input | 32 | Event vector base address |
| thr_ie_i | input | N_THREADS | Per-thread interrupt enable |
| thr_exc_i | input | N_THREADS | Per-thread exception-active flag |
| thr_mask_i | input | N_THREADS x N_LINES | Per-thread line masks |
| thr_prio_i | input | N_THREADS x PRIO_W | Per-thread priority value |
| thr_mode_i | input | N_THREADS x 2 | Per-thread run mode |
| thr_pc_i | input | N_THREADS x 32 | Per-thread current PC |
| thr_wpc_i | input | N_THREADS x 32 | Per-thread wait-resume PC |
| pend_o | output | N_LINES | Pending vector |
| adis_o | output | N_LINES | Auto-disable vector |
| wake_o | output | N_THREADS | Per-thread wake request |
| acc_valid_o | output | 1 | Acceptance record valid pulse |
| acc_tid_o | output | log2(N_THREADS) | Accepting thread index |
| acc_line_o | output | log2(N_LINES) | Accepted line number |
| acc_cause_o | output | 8 | Cause code for the thread |
| acc_elr_o | output | 32 | Exception-return address |
| acc_pc_o | output | 32 | Redirect PC |
| acc_leave_wait_o | output | 1 | Thread leaves wait mode |

## Verification
The bench goes after the cases a priority scan most easily gets wrong.

- **Ties on the largest priority value.** A design that picks the last tied thread, or the highest priority in the usual sense, hands the line to the wrong thread index.
- **Collisions on the pending vector.** These are a raise colliding with a clear, and a raise colliding with an acceptance. A wrong precedence leaves a stale pending bit, or drops a raised one.
- **Re-raise of an auto-disabled line.** It must stay pending and never be taken. A design that forgets the sticky bit delivers the line twice.
- **Return and redirect addresses.** Wait-mode threads, masked threads and scheduling-disabled mode are driven on purpose. A swapped PC source or a mis-shifted vector shows up as a wrong address.
- **Randomized sweeps.** Each sweep starts from reset, and every output is compared every cycle with an arithmetic model.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
    localparam int ADDR_W  = 32;
    localparam int CAUSE_W = 8;
    localparam int IDX_W   = 8;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [CAUSE_W-1:0] cause_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_WAIT = 2'd1,
        MODE_RUN  = 2'd2,
        MODE_RUN2 = 2'd3
    } run_mode_e;

    // Registered record of one acceptance
    typedef struct packed {
        idx_t   tid;
        idx_t   line;
        cause_t cause;
        addr_t  elr;
        addr_t  pc;
        logic   leave_wait;
    } acc_rec_t;

    function automatic cause_t make_cause(cause_t base, idx_t line);
        return base | cause_t'(line);
    endfunction

    function automatic addr_t make_vector(addr_t base, idx_t evt_base, idx_t line);
        addr_t evt;
        evt = addr_t'(evt_base) + addr_t'(line);
        return base | (evt << 2);
    endfunction
endpackage

// File: rtl/irq_pend_regs.sv
module irq_pend_regs #(
    parameter int N_LINES = 32,
    localparam int LINE_W = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] raise_i,
    input  logic [N_LINES-1:0] clear_i,
    input  logic               acc_i,
    input  logic [LINE_W-1:0]  acc_line_i,
    output logic [N_LINES-1:0] pend_o,
    output logic [N_LINES-1:0] adis_o
);
    logic [N_LINES-1:0] pend_q, adis_q, take_vec, pend_n;

    always_comb begin
        take_vec = '0;
        if (acc_i) take_vec[acc_line_i] = 1'b1;
        // raise beats clear; acceptance beats raise
        pend_n = ((pend_q | raise_i) & ~(clear_i & ~raise_i)) & ~take_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            adis_q <= '0;
        end else begin
            pend_q <= pend_n;
            adis_q <= adis_q | take_vec;
        end
    end

    assign pend_o = pend_q;
    assign adis_o = adis_q;

    AST_RAISE_LANDS: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (((pend_q | $past(take_vec)) & $past(raise_i)) == $past(raise_i))); // R2
    AST_ADIS_STICKY: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> ((adis_q & $past(adis_q)) == $past(adis_q))); // R6
endmodule

// File: rtl/irq_line_arb.sv
module irq_line_arb #(
    parameter int N_THREADS = 4,
    parameter int PRIO_W    = 3,
    localparam int TID_W    = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
    input  logic                              elig_i,
    input  logic                              sched_en_i,
    input  logic [N_THREADS-1:0]              ie_i,
    input  logic [N_THREADS-1:0]              exc_i,
    input  logic [N_THREADS-1:0]              mask_i,
    input  logic [N_THREADS-1:0][PRIO_W-1:0]  prio_i,
    output logic                              win_o,
    output logic [TID_W-1:0]                  tid_o
);
    logic [N_THREADS-1:0] qual;
    logic [PRIO_W-1:0]    top_p;

    always_comb begin
        qual  = {N_THREADS{elig_i}} & ie_i & ~exc_i & ~mask_i;
        top_p = '0;
        for (int t = 0; t < N_THREADS; t++) begin
            if (qual[t] && (prio_i[t] > top_p)) top_p = prio_i[t];
        end
        win_o = 1'b0;
        tid_o = '0;
        for (int t = 0; t < N_THREADS; t++) begin
            if (!win_o && qual[t] && (!sched_en_i || (prio_i[t] == top_p))) begin
                win_o = 1'b1;
                tid_o = TID_W'(t);
            end
        end
    end
endmodule

// File: rtl/irq_line_pick.sv
module irq_line_pick #(
    parameter int N_LINES = 32,
    parameter int TID_W   = 2,
    localparam int LINE_W = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0]             hit_i,
    input  logic [N_LINES-1:0][TID_W-1:0]  tid_i,
    output logic                           valid_o,
    output logic [LINE_W-1:0]              line_o,
    output logic [TID_W-1:0]               tid_o
);
    always_comb begin
        valid_o = 1'b0;
        line_o  = '0;
        tid_o   = '0;
        for (int l = 0; l < N_LINES; l++) begin
            if (!valid_o && hit_i[l]) begin
                valid_o = 1'b1;
                line_o  = LINE_W'(l);
                tid_o   = tid_i[l];
            end
        end
    end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int     N_LINES    = 32,
    parameter int     N_THREADS  = 4,
    parameter int     PRIO_W     = 3,
    parameter cause_t CAUSE_BASE = 8'hC0,
    parameter idx_t   EVT_BASE   = 8'd16,
    localparam int    LINE_W     = $clog2(N_LINES),
    localparam int    TID_W      = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 gie_i,
    input  logic                                 sched_en_i,
    input  logic [N_LINES-1:0]                   raise_i,
    input  logic [N_LINES-1:0]                   clear_i,
    input  logic [ADDR_W-1:0]                    vec_base_i,
    input  logic [N_THREADS-1:0]                 thr_ie_i,
    input  logic [N_THREADS-1:0]                 thr_exc_i,
    input  logic [N_THREADS-1:0][N_LINES-1:0]    thr_mask_i,
    input  logic [N_THREADS-1:0][PRIO_W-1:0]     thr_prio_i,
    input  logic [N_THREADS-1:0][1:0]            thr_mode_i,
    input  logic [N_THREADS-1:0][ADDR_W-1:0]     thr_pc_i,
    input  logic [N_THREADS-1:0][ADDR_W-1:0]     thr_wpc_i,
    output logic [N_LINES-1:0]                   pend_o,
    output logic [N_LINES-1:0]                   adis_o,
    output logic [N_THREADS-1:0]                 wake_o,
    output logic                                 acc_valid_o,
    output logic [TID_W-1:0]                     acc_tid_o,
    output logic [LINE_W-1:0]                    acc_line_o,
    output logic [CAUSE_W-1:0]                   acc_cause_o,
    output logic [ADDR_W-1:0]                    acc_elr_o,
    output logic [ADDR_W-1:0]                    acc_pc_o,
    output logic                                 acc_leave_wait_o
);
    logic [N_LINES-1:0]            pend_q, adis_q, line_hit;
    logic [N_LINES-1:0][TID_W-1:0] line_tid;
    logic                          pick_v;
    logic [LINE_W-1:0]             pick_line;
    logic [TID_W-1:0]              pick_tid;
    acc_rec_t                      rec_n, rec_q;
    logic                          valid_q;

    irq_pend_regs #(.N_LINES(N_LINES)) u_regs (
        .clk(clk), .rst(rst), .raise_i(raise_i), .clear_i(clear_i),
        .acc_i(pick_v), .acc_line_i(pick_line),
        .pend_o(pend_q), .adis_o(adis_q)
    );

    // One arbiter per line picks the thread that would take it
    for (genvar l = 0; l < N_LINES; l++) begin : g_line
        logic [N_THREADS-1:0] mbit;
        always_comb begin
            for (int t = 0; t < N_THREADS; t++) mbit[t] = thr_mask_i[t][l];
        end
        irq_line_arb #(.N_THREADS(N_THREADS), .PRIO_W(PRIO_W)) u_arb (
            .elig_i(gie_i & pend_q[l] & ~adis_q[l]),
            .sched_en_i(sched_en_i),
            .ie_i(thr_ie_i), .exc_i(thr_exc_i), .mask_i(mbit),
            .prio_i(thr_prio_i),
            .win_o(line_hit[l]), .tid_o(line_tid[l])
        );
    end

    irq_line_pick #(.N_LINES(N_LINES), .TID_W(TID_W)) u_pick (
        .hit_i(line_hit), .tid_i(line_tid),
        .valid_o(pick_v), .line_o(pick_line), .tid_o(pick_tid)
    );

    always_comb begin
        rec_n.tid   = idx_t'(pick_tid);
        rec_n.line  = idx_t'(pick_line);
        rec_n.cause = make_cause(CAUSE_BASE, idx_t'(pick_line));
        rec_n.pc    = make_vector(vec_base_i, EVT_BASE, idx_t'(pick_line));
        rec_n.leave_wait = (thr_mode_i[pick_tid] == MODE_WAIT);
        rec_n.elr   = rec_n.leave_wait ? thr_wpc_i[pick_tid] : thr_pc_i[pick_tid];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rec_q   <= '0;
        end else begin
            valid_q <= pick_v;
            if (pick_v) rec_q <= rec_n;
        end
    end

    always_comb begin
        for (int t = 0; t < N_THREADS; t++)
            wake_o[t] = (|pend_q) && (thr_mode_i[t] != MODE_OFF);
    end

    assign pend_o           = pend_q;
    assign adis_o           = adis_q;
    assign acc_valid_o      = valid_q;
    assign acc_tid_o        = rec_q.tid[TID_W-1:0];
    assign acc_line_o       = rec_q.line[LINE_W-1:0];
    assign acc_cause_o      = rec_q.cause;
    assign acc_elr_o        = rec_q.elr;
    assign acc_pc_o         = rec_q.pc;
    assign acc_leave_wait_o = rec_q.leave_wait;

    AST_TAKEN_NOT_PENDING: assert property (@(posedge clk) disable iff (rst) valid_q |-> !pend_q[acc_line_o]); // R6
    AST_TAKEN_DISABLED: assert property (@(posedge clk) disable iff (rst) valid_q |-> adis_q[acc_line_o]); // R6
    AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (rst) valid_q |=> !(valid_q && (acc_line_o == $past(acc_line_o)))); // R6
    AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> (!valid_q && (pend_q == '0) && (adis_q == '0))); // R1
endmodule

// File: tb/irq_accept_unit_tb_top.sv
module irq_accept_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 32;
    localparam int NT = 4;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic gie, sched;
    logic [NL-1:0] raise, clear;
    logic [31:0] evb;
    logic [NT-1:0] ie, exc;
    logic [NT-1:0][NL-1:0] mask;
    logic [NT-1:0][PW-1:0] prio;
    logic [NT-1:0][1:0] mode;
    logic [NT-1:0][31:0] pc, wpc;

    logic [NL-1:0] pend_o, adis_o;
    logic [NT-1:0] wake_o;
    logic acc_valid_o, acc_leave_wait_o;
    logic [1:0] acc_tid_o;
    logic [4:0] acc_line_o;
    logic [7:0] acc_cause_o;
    logic [31:0] acc_elr_o, acc_pc_o;

    irq_accept_unit #(.N_LINES(NL), .N_THREADS(NT), .PRIO_W(PW)) dut_i (
        .clk(clk), .rst(rst), .gie_i(gie), .sched_en_i(sched),
        .raise_i(raise), .clear_i(clear), .vec_base_i(evb),
        .thr_ie_i(ie), .thr_exc_i(exc), .thr_mask_i(mask), .thr_prio_i(prio),
        .thr_mode_i(mode), .thr_pc_i(pc), .thr_wpc_i(wpc),
        .pend_o(pend_o), .adis_o(adis_o), .wake_o(wake_o),
        .acc_valid_o(acc_valid_o), .acc_tid_o(acc_tid_o), .acc_line_o(acc_line_o),
        .acc_cause_o(acc_cause_o), .acc_elr_o(acc_elr_o), .acc_pc_o(acc_pc_o),
        .acc_leave_wait_o(acc_leave_wait_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [NL-1:0] m_pend, m_adis;
    logic e_valid, e_lw;
    int e_tid, e_line;
    logic [31:0] e_elr, e_pc;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference: decide from model state and current inputs, then advance state
    task automatic model_step();
        int bt;
        bit found = 0;
        e_valid = 0;
        for (int l = 0; l < NL; l++) begin
            if (!found && gie && m_pend[l] && !m_adis[l]) begin
                bt = -1;
                for (int t = 0; t < NT; t++) begin
                    if (ie[t] && !exc[t] && !mask[t][l]) begin
                        if (bt < 0) bt = t;
                        else if (sched && prio[t] > prio[bt]) bt = t;
                    end
                end
                if (bt >= 0) begin
                    found = 1; e_valid = 1; e_tid = bt; e_line = l;
                    e_pc = evb | (32'(16 + l) << 2);
                    e_lw = (mode[bt] == 2'd1);
                    e_elr = e_lw ? wpc[bt] : pc[bt];
                end
            end
        end
        m_pend = (m_pend | raise) & ~(clear & ~raise);
        if (found) begin
            m_pend[e_line] = 1'b0;
            m_adis[e_line] = 1'b1;
        end
    endtask

    task automatic check_all();
        logic [NT-1:0] ew;
        for (int t = 0; t < NT; t++) ew[t] = (|m_pend) && (mode[t] != 2'd0);
        chk("R2 pend", 64'(pend_o), 64'(m_pend));
        chk("R6 adis", 64'(adis_o), 64'(m_adis));
        chk("R11 valid", 64'(acc_valid_o), 64'(e_valid));
        chk("R10 wake", 64'(wake_o), 64'(ew));
        if (e_valid && acc_valid_o) begin
            chk("R5 tid", 64'(acc_tid_o), 64'(e_tid));
            chk("R4 line", 64'(acc_line_o), 64'(e_line));
            chk("R7 cause", 64'(acc_cause_o), 64'(8'hC0 | 8'(e_line)));
            chk("R8 redirect", 64'(acc_pc_o), 64'(e_pc));
            chk("R9 elr", 64'(acc_elr_o), 64'(e_elr));
            chk("R9 leave_wait", 64'(acc_leave_wait_o), 64'(e_lw));
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all();
        raise = '0;
        clear = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1; raise = '0; clear = '0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 1'b0;
        m_pend = '0; m_adis = '0; e_valid = 0;
        chk("R1 pend", 64'(pend_o), 64'h0);
        chk("R1 adis", 64'(adis_o), 64'h0);
        chk("R1 valid", 64'(acc_valid_o), 64'h0);
    endtask

    initial begin
        gie = 0; sched = 0; raise = '0; clear = '0; evb = 32'h8000_0000;
        ie = '1; exc = '0; mask = '0; prio = '0; mode = {2'd2, 2'd2, 2'd2, 2'd0};
        for (int t = 0; t < NT; t++) begin
            pc[t] = 32'h1000 + 32'(t) * 32'h100;
            wpc[t] = 32'h2000 + 32'(t) * 32'h100;
        end
        do_reset();

        // R2: raise/clear edits, raise wins on same bit
        raise = 32'h0000_00F0; tick();
        clear = 32'h0000_0030; raise = 32'h0000_0020; tick();
        chk("R2 raise beats clear", 64'(pend_o), 64'hE0);
        tick();
        chk("R2 zero masks", 64'(pend_o), 64'hE0);
        chk("R10 off thread not woken", 64'(wake_o), 64'hE);

        // R5: largest priority value, tie to lowest index; R4 lowest line
        gie = 1; sched = 1; prio = {3'd1, 3'd5, 3'd5, 3'd2}; tick();
        chk("R5 tie lowest index", 64'(acc_tid_o), 64'd1);
        chk("R4 lowest line", 64'(acc_line_o), 64'd5);

        // R3 mask, R9 wait mode, R8 vector, R7 cause
        mask[1][6] = 1'b1; mode[2] = 2'd1; wpc[2] = 32'h1234; tick();
        chk("R3 masked thread skipped", 64'(acc_tid_o), 64'd2);
        chk("R9 wait resume pc", 64'(acc_elr_o), 64'h1234);
        chk("R9 leave wait", 64'(acc_leave_wait_o), 64'd1);
        chk("R8 redirect", 64'(acc_pc_o), 64'h8000_0058);
        chk("R7 cause", 64'(acc_cause_o), 64'hC6);

        // R6: acceptance beats same-cycle raise
        raise = 32'h80; tick();
        chk("R6 accept beats raise", 64'(pend_o[7]), 64'd0);
        chk("R9 running elr", 64'(acc_elr_o), 64'h1100);

        // R6: auto-disabled line stays pending, never taken
        raise = 32'h20; tick(); tick();
        chk("R6 disabled line not taken", 64'(acc_valid_o), 64'd0);
        chk("R6 disabled line stays pending", 64'(pend_o[5]), 64'd1);

        // R5 scheduling off, R3 exception-active thread skipped
        do_reset();
        sched = 0; prio = {3'd7, 3'd1, 3'd1, 3'd0}; mode = '1; mask = '0;
        raise = 32'h1; tick(); tick();
        chk("R5 sched off lowest index", 64'(acc_tid_o), 64'd0);
        exc = 4'b0001; raise = 32'h2; tick(); tick();
        chk("R3 exception thread skipped", 64'(acc_tid_o), 64'd1);
        gie = 0; raise = 32'h4; tick(); tick();
        chk("R3 global enable off", 64'(acc_valid_o), 64'd0);

        // Sweeps against the model
        for (int trial = 0; trial < 300; trial++) begin
            do_reset();
            for (int c = 0; c < 8; c++) begin
                gie = ($urandom % 8) != 0;
                sched = $urandom % 2;
                ie = 4'($urandom); exc = 4'($urandom) & 4'($urandom);
                for (int t = 0; t < NT; t++) begin
                    mask[t] = $urandom & $urandom & $urandom;
                    prio[t] = 3'($urandom);
                    mode[t] = 2'($urandom);
                    pc[t] = $urandom & 32'hFFFF_FFFC;
                    wpc[t] = $urandom & 32'hFFFF_FFFC;
                end
                evb = $urandom & 32'hFFFF_F000;
                raise = $urandom & $urandom;
                clear = $urandom & $urandom;
                tick();
            end
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule